// File: doc/BRIEF.md
# LIN Wake Filter and Dominant Timeout Guard

This block holds the digital timing filters placed around a LIN transceiver's bus driver. While the node sits in a low-power state, it looks for two kinds of wake request.

- **Remote wake:** the bus goes dominant (a falling edge) and then stays dominant for a filter time.
- **Local wake:** the local wake input falls and then stays low for a longer filter time. The longer time keeps supply transients from waking the node.

Each recognised request comes out as a one-cycle pulse.

On the transmit side, the block turns the transmit data input into a driver control. A low TXD pulls the bus dominant and a high TXD leaves it recessive. The block has no output for a received level; `bus_rx` is only an input to the remote wake filter.

If TXD stays low past a dominant timeout, the block forces the driver off. It keeps the driver off until TXD returns high, so a stuck controller cannot block the bus.

All times are counted in pulses of a one-microsecond `us_tick` strobe. The defaults are 90 ticks for the bus filter, 130 ticks for the wake pin filter and 10000 ticks for the dominant timeout. The inputs are expected to be already synchronous to `clk`.

Top module: `lin_wake_guard`

## Requirements
- R1: With `lp_mode`=1, `bus_rx` falling from 1 to 0 between two consecutive clock samples arms the bus filter. The cycle in which the fall is seen counts no tick. `us_tick` pulses are counted only in later cycles while `bus_rx` stays 0. On the BUS_FILT_TICKS-th counted tick, `remote_wake` is 1 in the next cycle. With a tick every cycle, that is BUS_FILT_TICKS+1 cycles after the fall is sampled.
- R2: The same rule applies to `wake_in` with WAKE_FILT_TICKS, producing `local_wake`.
- R3: If the watched input returns to 1 before the count completes, the pending wake is cancelled. Only a new 1-to-0 fall can re-arm the filter. An input held low past a wake gives no second wake. An input that is already low when `lp_mode` rises gives no wake.
- R4: Wake detection works only while `lp_mode`=1. When `lp_mode`=0, both filters are idle and no wake pulse is produced.
- R5: `remote_wake` and `local_wake` are each high for exactly one cycle per recognised wake.
- R6: `drv_dom` (1 = pull the bus dominant) is registered. It is 1 only if, at the previous clock sample, `txd` was 0, transmit was allowed and the timeout had not fired. A 1 on `txd` gives `drv_dom`=0.
- R7: While `txd` is 0, `us_tick` pulses are counted, including the tick in the sample where `txd` first reads 0. At the sample that brings the count to DOM_TMO_TICKS, `drv_dom` goes to 0.
- R8: After a timeout, `drv_dom` stays 0 for as long as `txd` stays 0. A sample with `txd`=1 clears the timeout and the count, so a later low `txd` drives dominant again.
- R9: `supply_uv`=1 or `lp_mode`=1 forces `drv_dom` to 0.
- R10: During and right after the synchronous reset `rst`, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle time base strobe, nominally one per microsecond |
| lp_mode | input | 1 | 1 = low-power (silent or sleep) mode: wake detect on, transmit off |
| supply_uv | input | 1 | Supply undervoltage flag; 1 disables transmit |
| bus_rx | input | 1 | Digitized bus level, 0 = dominant |
| wake_in | input | 1 | Local wake input level, active low |
| txd | input | 1 | Transmit data, 0 = dominant |
| remote_wake | output | 1 | One-cycle pulse on a recognised bus wake |
| local_wake | output | 1 | One-cycle pulse on a recognised local wake |
| drv_dom | output | 1 | Driver control, 1 = pull the bus dominant |

## Verification
The assertions assume that every input changes only between clock edges. They also assume `us_tick` is an ordinary level sampled at each edge, so no input glitches within a cycle.

The bench keeps to these assumptions by changing inputs only at falling clock edges. Before each wake attempt it holds both wake inputs high for several cycles, so a fall is always seen from a known high level. Tick density is drawn at random around each filter and timeout threshold. The bench's expected values come from counting the ticks it drove itself.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  // Wake filter state: waiting for a fall, or counting a held low.
  typedef enum logic {
    FLT_IDLE  = 1'b0,
    FLT_ARMED = 1'b1
  } flt_state_t;

  // Wake sources, one filter each.
  localparam int NUM_WAKE_SRC = 2;
  localparam int SRC_BUS      = 0;
  localparam int SRC_PIN      = 1;

endpackage

// File: rtl/lin_edge_hold_filter.sv
module lin_edge_hold_filter
  import lin_wake_pkg::*;
#(
  parameter int HOLD_TICKS = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic sig_in,
  output logic wake_pulse
);

  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  flt_state_t    state;
  logic          prev_lvl;
  logic [CW-1:0] cnt;
  logic          fall_seen;

  assign fall_seen = prev_lvl & ~sig_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FLT_IDLE;
      prev_lvl   <= 1'b0;
      cnt        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      prev_lvl   <= sig_in;
      wake_pulse <= 1'b0;
      if (!en) begin
        state <= FLT_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          FLT_IDLE: begin
            if (fall_seen) begin
              state <= FLT_ARMED;
              cnt   <= '0;
            end
          end
          FLT_ARMED: begin
            if (sig_in) begin
              state <= FLT_IDLE;
            end else if (tick) begin
              if (cnt == LAST) begin
                wake_pulse <= 1'b1;
                state      <= FLT_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= FLT_IDLE;
        endcase
      end
    end
  end

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);  // R5

  AST_WAKE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wake_pulse);  // R4

  AST_WAKE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> !$past(sig_in));  // R1

  AST_ARM_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (state == FLT_IDLE && en && !fall_seen) |=> state == FLT_IDLE);  // R3

endmodule

// File: rtl/lin_txd_dom_guard.sv
module lin_txd_dom_guard #(
  parameter int TMO_TICKS = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic txd,
  input  logic tx_allow,
  output logic drv_dom
);

  localparam int CW = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          tmo_latched;
  logic          tmo_now;

  // The tick that completes the count turns the driver off in the same sample.
  assign tmo_now = ~txd & ~tmo_latched & tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      tmo_latched <= 1'b0;
      drv_dom     <= 1'b0;
    end else begin
      if (txd) begin
        cnt         <= '0;
        tmo_latched <= 1'b0;
      end else if (!tmo_latched && tick) begin
        if (cnt == LAST) tmo_latched <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
      drv_dom <= ~txd & tx_allow & ~tmo_latched & ~tmo_now;
    end
  end

  AST_DOM_NEEDS_TXD_LOW: assert property (@(posedge clk) disable iff (rst)
    drv_dom |-> !$past(txd));  // R6

  AST_DOM_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (rst)
    drv_dom |-> $past(tx_allow));  // R9

  AST_TMO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tmo_latched && !txd) |=> (tmo_latched && !drv_dom));  // R8

  AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    txd |=> (!tmo_latched && cnt == '0));  // R8

endmodule

// File: rtl/lin_wake_guard.sv
module lin_wake_guard
  import lin_wake_pkg::*;
#(
  parameter int BUS_FILT_TICKS  = 90,
  parameter int WAKE_FILT_TICKS = 130,
  parameter int DOM_TMO_TICKS   = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic lp_mode,
  input  logic supply_uv,
  input  logic bus_rx,
  input  logic wake_in,
  input  logic txd,
  output logic remote_wake,
  output logic local_wake,
  output logic drv_dom
);

  logic [NUM_WAKE_SRC-1:0] src_lvl;
  logic [NUM_WAKE_SRC-1:0] src_wake;
  logic                    tx_allow;

  assign src_lvl[SRC_BUS] = bus_rx;
  assign src_lvl[SRC_PIN] = wake_in;
  assign tx_allow         = ~supply_uv & ~lp_mode;

  for (genvar g = 0; g < NUM_WAKE_SRC; g++) begin : g_wake
    localparam int HOLD = (g == SRC_BUS) ? BUS_FILT_TICKS : WAKE_FILT_TICKS;
    lin_edge_hold_filter #(.HOLD_TICKS(HOLD)) u_flt (
      .clk        (clk),
      .rst        (rst),
      .en         (lp_mode),
      .tick       (us_tick),
      .sig_in     (src_lvl[g]),
      .wake_pulse (src_wake[g])
    );
  end

  assign remote_wake = src_wake[SRC_BUS];
  assign local_wake  = src_wake[SRC_PIN];

  lin_txd_dom_guard #(.TMO_TICKS(DOM_TMO_TICKS)) u_txg (
    .clk      (clk),
    .rst      (rst),
    .tick     (us_tick),
    .txd      (txd),
    .tx_allow (tx_allow),
    .drv_dom  (drv_dom)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!remote_wake && !local_wake && !drv_dom));  // R10

endmodule

// File: tb/tb_lin_wake_guard.sv
module tb_lin_wake_guard;

  localparam int BUS_T  = 90;
  localparam int WAKE_T = 130;
  localparam int TMO_T  = 10000;

  logic clk = 1'b0, rst = 1'b1, us_tick = 1'b0, lp_mode = 1'b0, supply_uv = 1'b0;
  logic bus_rx = 1'b1, wake_in = 1'b1, txd = 1'b1;
  logic remote_wake, local_wake, drv_dom;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lin_wake_guard #(
    .BUS_FILT_TICKS(BUS_T), .WAKE_FILT_TICKS(WAKE_T), .DOM_TMO_TICKS(TMO_T)
  ) dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .lp_mode(lp_mode),
    .supply_uv(supply_uv), .bus_rx(bus_rx), .wake_in(wake_in), .txd(txd),
    .remote_wake(remote_wake), .local_wake(local_wake), .drv_dom(drv_dom)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit draw_tick(int pct);
    return (($urandom % 100) < pct);
  endfunction

  function automatic int wake_expect(bit en, bit this_src, int ticks, int limit);
    return (en && this_src && ticks >= limit) ? 1 : 0;
  endfunction

  // One wake attempt: ch 0 = bus, 1 = wake pin; input low for len cycles.
  task automatic run_wake(bit ch, bit en, int len, int pct, string tag, bit chk_lat);
    int tk = 0, rcnt = 0, lcnt = 0, first = -1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rcnt += int'(remote_wake); lcnt += int'(local_wake);
      lp_mode = en; bus_rx = 1'b1; wake_in = 1'b1; us_tick = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ((remote_wake || local_wake) && first < 0) first = i;
      rcnt += int'(remote_wake); lcnt += int'(local_wake);
      if (ch == 1'b0) bus_rx = 1'b0; else wake_in = 1'b0;
      us_tick = draw_tick(pct);
      if (i > 0 && us_tick) tk++;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if ((remote_wake || local_wake) && first < 0) first = len + i;
      rcnt += int'(remote_wake); lcnt += int'(local_wake);
      bus_rx = 1'b1; wake_in = 1'b1; us_tick = 1'b0;
    end
    check(rcnt == wake_expect(en, ch == 1'b0, tk, BUS_T), {tag, " remote_wake count"},
          rcnt, wake_expect(en, ch == 1'b0, tk, BUS_T));
    check(lcnt == wake_expect(en, ch == 1'b1, tk, WAKE_T), {tag, " local_wake count"},
          lcnt, wake_expect(en, ch == 1'b1, tk, WAKE_T));
    if (chk_lat)
      check(first == ((ch == 1'b0) ? BUS_T : WAKE_T) + 1, {tag, " wake latency"},
            first, ((ch == 1'b0) ? BUS_T : WAKE_T) + 1);
  endtask

  // One transmit burst: txd low for len cycles, then released.
  task automatic run_tx(int len, int pct, bit uv, bit lp, string tag);
    int cum = 0, bad = 0;
    bit expd = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      txd = 1'b1; supply_uv = uv; lp_mode = lp; us_tick = 1'b0;
      bus_rx = 1'b1; wake_in = 1'b1;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0 && drv_dom !== expd) bad++;
      txd = 1'b0;
      us_tick = draw_tick(pct);
      cum += int'(us_tick);
      expd = !uv && !lp && (cum < TMO_T);
    end
    @(negedge clk);
    if (drv_dom !== expd) bad++;
    txd = 1'b1; us_tick = 1'b0;
    @(negedge clk);
    check(drv_dom === 1'b0, {tag, " drv_dom after txd release (R6)"}, int'(drv_dom), 0);
    check(bad == 0, {tag, " drv_dom cycle mismatches"}, bad, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1A2B);
    repeat (4) begin
      @(negedge clk);
      check(!remote_wake && !local_wake && !drv_dom, "R10 outputs in reset",
            int'({remote_wake, local_wake, drv_dom}), 0);
    end
    @(negedge clk); rst = 1'b0;

    // R1 / R2 exact thresholds with a tick every cycle
    run_wake(1'b0, 1'b1, BUS_T + 1, 100, "R1 bus held at threshold", 1'b1);
    run_wake(1'b0, 1'b1, BUS_T,     100, "R3 bus released one cycle early", 1'b0);
    run_wake(1'b1, 1'b1, WAKE_T + 1, 100, "R2 pin held at threshold", 1'b1);
    run_wake(1'b1, 1'b1, WAKE_T,     100, "R3 pin released one cycle early", 1'b0);
    // R4 no wake outside low-power mode
    run_wake(1'b0, 1'b0, 3 * BUS_T,  100, "R4 bus wake in normal mode", 1'b0);
    run_wake(1'b1, 1'b0, 3 * WAKE_T, 100, "R4 pin wake in normal mode", 1'b0);
    // R5 long hold gives a single pulse; R3 no re-arm without a new fall
    run_wake(1'b0, 1'b1, 4 * BUS_T, 100, "R5 bus long hold single pulse", 1'b0);
    run_wake(1'b1, 1'b1, 4 * WAKE_T, 100, "R5 pin long hold single pulse", 1'b0);

    // R3 input already low when low-power mode starts
    begin
      int seen = 0;
      @(negedge clk); lp_mode = 1'b0; bus_rx = 1'b0; wake_in = 1'b0; us_tick = 1'b1;
      repeat (3) @(negedge clk);
      lp_mode = 1'b1;
      repeat (2 * WAKE_T) begin
        @(negedge clk);
        seen += int'(remote_wake) + int'(local_wake);
      end
      check(seen == 0, "R3 low before mode entry gives no wake", seen, 0);
      bus_rx = 1'b1; wake_in = 1'b1; us_tick = 1'b0;
    end

    // Random tick density around the filter thresholds
    for (int t = 0; t < 40; t++) begin
      bit ch = 1'($urandom % 2);
      int base = ch ? WAKE_T : BUS_T;
      int len = base + int'($urandom % 80);
      int pct = 60 + int'($urandom % 41);
      run_wake(ch, 1'b1, len, pct, ch ? "R2 random pin" : "R1 random bus", 1'b0);
    end

    // Transmit path
    run_tx(200, 100, 1'b0, 1'b0, "R6 normal dominant burst");
    run_tx(TMO_T + 40, 100, 1'b0, 1'b0, "R7 timeout with tick every cycle");
    run_tx(60, 100, 1'b0, 1'b0, "R8 dominant again after release");
    run_tx(TMO_T - 1, 100, 1'b0, 1'b0, "R8 just under timeout");
    run_tx(TMO_T - 1, 100, 1'b0, 1'b0, "R8 count cleared by release");
    run_tx(TMO_T + 3000, 80, 1'b0, 1'b0, "R7 timeout with sparse ticks");
    run_tx(100, 100, 1'b1, 1'b0, "R9 undervoltage blocks driver");
    run_tx(100, 100, 1'b0, 1'b1, "R9 low-power mode blocks driver");
    for (int t = 0; t < 6; t++)
      run_tx(50 + int'($urandom % 400), 50 + int'($urandom % 51), 1'($urandom % 2),
             1'b0, "R6 random burst");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule